// File: doc/BRIEF.md
# Triangle-Swept PWM Generator

This block drives a pulse-width-modulated output whose duty cycle ramps up and down in a triangle between 0 and 100 percent. Each single-cycle pulse on the step input moves the duty value by a fixed amount. A two-state direction controller turns the ramp around at the top and bottom limits. A free-running period counter is compared against the duty value to form the output. The duty value is also available on a port so it can be observed.

Typical use: a slow strobe, derived elsewhere, feeds the step input. The output then pulses with a smoothly rising and falling average level, for example to make an LED "breathe". The enable input gates the output pin only. The ramp keeps running while the output is disabled.

Top module: `tri_pwm`

## Requirements
- R1: While `rst` is high, and on the first cycles after it is released, `duty` is 0, the ramp direction is upward, and `pwm_out` is low.
- R2: `duty` changes only on rising clock edges where `step` is high. On every other edge it keeps its value.
- R3: While the ramp is rising, each sampled `step` adds 2 to `duty`.
- R4: When `duty` is 100, the next `step` takes it to 98, including when steps arrive on back-to-back cycles. `duty` never exceeds 100.
- R5: While the ramp is falling, each sampled `step` subtracts 2 from `duty`.
- R6: When `duty` is 0, the next `step` takes it to 2. `duty` never wraps below 0.
- R7: The period counter counts 0 to 99 and wraps. While `en` is high, `pwm_out` is high when the counter is below `duty`. Over any 100 consecutive cycles with `duty` constant, `pwm_out` is therefore high for exactly `duty` cycles.
- R8: A `duty` of 0 keeps `pwm_out` low at all times. A `duty` of 100 keeps `pwm_out` high at all times while `en` is high.
- R9: While `en` is low, `pwm_out` stays low, and `step` pulses still move `duty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| step | input | 1 | Single-cycle strobe that advances the duty value |
| en | input | 1 | Output enable; low forces `pwm_out` low |
| pwm_out | output | 1 | Pulse-width-modulated output |
| duty | output | 7 | Current duty value, 0 to 100, unsigned |

## Verification
The bench builds the block with its default values: a top limit of 100, a step of 2, and a 100-cycle period. With these values a full ramp up and down takes exactly 100 steps, so complete sweeps with both turnarounds fit in a short run. Steps are issued back to back, so the turnaround at 100 and at 0 is hit on the very edge where the limit is reached. The bench also counts high cycles over whole periods at duty values 0, 6 and 100. This covers the never-high and always-high ends of the comparison as well as a midpoint.

// File: rtl/tri_pwm.sv
module tri_pwm #(
  parameter int MAX_DUTY   = 100,
  parameter int STEP       = 2,
  parameter int PWM_PERIOD = 100,
  localparam int TOP = (PWM_PERIOD > MAX_DUTY) ? PWM_PERIOD : MAX_DUTY + 1,
  localparam int W   = $clog2(TOP + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         en,
  output logic         pwm_out,
  output logic [W-1:0] duty
);

  localparam logic [W-1:0] MAXV  = W'(MAX_DUTY);
  localparam logic [W-1:0] STEPV = W'(STEP);
  localparam logic [W-1:0] LAST  = W'(PWM_PERIOD - 1);

  typedef enum logic {RISE = 1'b0, FALL = 1'b1} dir_t;

  dir_t         dir_q, dir_d;
  logic [W-1:0] cnt_q;
  logic [W-1:0] duty_up, duty_dn;

  always_comb begin
    if (dir_q == RISE) dir_d = (duty > MAXV - W'(1)) ? FALL : RISE;
    else               dir_d = (duty < W'(1))        ? RISE : FALL;
  end

  assign duty_up = (duty > MAXV - STEPV) ? MAXV : duty + STEPV;
  assign duty_dn = (duty < STEPV) ? '0 : duty - STEPV;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dir_q <= RISE;
      duty  <= '0;
    end else begin
      dir_q <= dir_d;
      if (step) duty <= (dir_d == RISE) ? duty_up : duty_dn;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign pwm_out = en && (cnt_q < duty);

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst) duty <= MAXV); // R4
  AST_HOLD:       assert property (@(posedge clk) disable iff (rst) !step |=> $stable(duty)); // R2
  AST_STEP_SIZE:  assert property (@(posedge clk) disable iff (rst)
                    step |=> (duty == $past(duty) + STEPV || duty == $past(duty) - STEPV
                              || duty == MAXV || duty == '0)); // R3
  AST_PEAK_TURN:  assert property (@(posedge clk) disable iff (rst)
                    (step && duty == MAXV) |=> duty == MAXV - STEPV); // R4
  AST_FLOOR_TURN: assert property (@(posedge clk) disable iff (rst)
                    (step && duty == '0) |=> duty == STEPV); // R6
  AST_ZERO_LOW:   assert property (@(posedge clk) disable iff (rst) duty == '0 |-> !pwm_out); // R8
  AST_FULL_HIGH:  assert property (@(posedge clk) disable iff (rst)
                    (duty == MAXV && en) |-> pwm_out); // R8
  AST_EN_LOW:     assert property (@(posedge clk) disable iff (rst) !en |-> !pwm_out); // R9

endmodule

// File: tb/tri_pwm_test.sv
module tri_pwm_test;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step = 1'b0;
  logic       en = 1'b1;
  logic       pwm_out;
  logic [6:0] duty;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  tri_pwm uut (.clk(clk), .rst(rst), .step(step), .en(en), .pwm_out(pwm_out), .duty(duty));

  always #(CLK_NS/2) clk = ~clk;

  // {steps applied back to back, expected duty afterwards}
  localparam int VEC [12][2] = '{
    '{1, 2}, '{4, 10}, '{40, 90}, '{5, 100}, '{1, 98}, '{1, 96},
    '{47, 2}, '{1, 0}, '{1, 2}, '{49, 100}, '{50, 0}, '{3, 6}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step = 1'b1;
    end
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic count_high(output int hi);
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check("R1 duty in reset", duty, 0);
    check("R1 pwm in reset", pwm_out, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 duty after reset", duty, 0);

    // R3 R4 R5 R6: table of step bursts across both turnarounds
    for (int v = 0; v < 12; v++) begin
      pulse(VEC[v][0]);
      check($sformatf("R3/R4/R5/R6 vector %0d", v), duty, VEC[v][1]);
    end

    // R2: no step, duty holds
    repeat (20) @(negedge clk);
    check("R2 hold", duty, 6);

    // R7: high cycles per period equal duty
    count_high(hi);
    check("R7 high count at 6", hi, 6);

    pulse(47);
    check("R4 climb to top", duty, 100);
    count_high(hi);
    check("R8 always high at 100", hi, 100);

    // R9: disabled output, ramp still moves
    en = 1'b0;
    count_high(hi);
    check("R9 pwm low with en low", hi, 0);
    pulse(1);
    check("R9 duty moves with en low", duty, 98);
    en = 1'b1;

    pulse(49);
    check("R6 bottom", duty, 0);
    count_high(hi);
    check("R8 always low at 0", hi, 0);

    pulse(5);
    check("R3 rise after bottom", duty, 10);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", duty, 0);
    rst = 1'b0;
    pulse(1);
    check("R1 direction up after reset", duty, 2);

    finished = 1'b1;
    finish_run();
  end
endmodule